// File: doc/BRIEF.md
# Video-Priority Memory Contention Controller

This block shares one region of video RAM between a CPU and a video fetch engine, and the video side always has priority. It does not use a bus request and grant handshake with the CPU. Instead it produces the CPU clock itself, as a half-rate copy of the master clock. When the video engine owns the memory and the CPU wants the same memory, it freezes the CPU by keeping that clock in its high phase.

A raster timing generator supplies a display-active flag and a one-cycle fetch-slot strobe. A fetch slot in the picture area normally starts a video grant that lasts a fixed number of master cycles. A CPU access to the contended window (memory, or an even-numbered I/O port) that arrives during the grant is held off. A CPU access that is already running when a slot arrives is never aborted. That slot's fetch is dropped instead, and a missed-fetch flag tells the pixel path to show white "snow" for it. A separate one-shot raises a fixed-length interrupt request on each vertical refresh event.

Top module: `vram_contend_ctrl`

## Requirements
- R1: A memory cycle is contended only when its address lies from 0x4000 up to 0x7FFF inclusive. A memory cycle outside that window never holds the CPU clock, even while a video grant is active.
- R2: An I/O cycle is contended only when address bit 0 is 0. An I/O cycle with bit 0 equal to 1 never holds the CPU clock and never causes a missed fetch.
- R3: While `disp_active_i` is low, the block asserts no video grant and no missed-fetch flag and never holds the CPU clock, whatever the fetch-slot and CPU inputs are.
- R4: To stall the CPU, `cpu_clk_o` is kept at 1. It is never held at 0: every low cycle is followed by a high cycle. `cpu_clk_o` is 1 out of reset.
- R5: A fetch slot in the picture area with no contended CPU access in progress raises `vid_grant_o` on the next master cycle, for exactly FETCH_LEN (default 4) master cycles.
- R6: A contended access is in progress when a contended cycle has its read or write strobe asserted and no grant is active. A fetch slot in the picture area that meets such an access starts no grant and sets `snow_o` on the next master cycle.
- R7: `snow_o` keeps its value between fetch slots. Every new fetch slot reloads it, and a slot with no contended access in progress clears it.
- R8: The clock is released on the first master edge after `vid_grant_o` has gone low. A contended request aligned to a high clock phase sees FETCH_LEN-1 extra held cycles.
- R9: With no grant active, `cpu_clk_o` toggles on every master edge, so a CPU request adds zero cycles.
- R10: A rising edge on `vsync_i` raises `irq_o` on the next master cycle for exactly IRQ_LEN (default 32) cycles. It then drops with no acknowledge.
- R11: During reset, `cpu_clk_o` is 1 and `vid_grant_o`, `snow_o` and `irq_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running master clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cpu_addr_i | input | ADDR_W (16) | CPU address bus |
| cpu_mem_req_i | input | 1 | CPU memory cycle request |
| cpu_io_req_i | input | 1 | CPU I/O cycle request |
| cpu_rd_i | input | 1 | CPU read strobe |
| cpu_wr_i | input | 1 | CPU write strobe |
| disp_active_i | input | 1 | Raster is inside the picture area |
| fetch_slot_i | input | 1 | One-cycle strobe that a video fetch is due |
| vsync_i | input | 1 | Vertical refresh event |
| cpu_clk_o | output | 1 | Gated CPU clock, stretched high to stall |
| vid_grant_o | output | 1 | Video engine owns the contended memory |
| snow_o | output | 1 | Fetch of the current slot was missed; show white |
| irq_o | output | 1 | Maskable interrupt request, fixed length |

## Verification
A fetch slot and a contended CPU cycle can land on the same master edge. The outcome then depends on whether the CPU strobe is already asserted: a stretched clock with a grant, or a dropped fetch with snow. The bench aligns every vector to a high CPU clock phase and applies the slot and the request together, with and without the strobe, for in-window, edge-of-window, outside-window and odd and even I/O addresses. In each case it counts held clock cycles, grant cycles and the snow flag against values worked out from the requirements.

// File: rtl/vcc_pkg.sv
package vcc_pkg;

   typedef enum logic {
      FA_IDLE  = 1'b0,
      FA_GRANT = 1'b1
   } fa_state_e;

   function automatic int unsigned cnt_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

   function automatic bit is_pow2(input longint unsigned n);
      return (n != 0) && ((n & (n - 1)) == 0);
   endfunction

endpackage

// File: rtl/vcc_decode.sv
module vcc_decode #(
   parameter int unsigned ADDR_W     = 16,
   parameter int unsigned CONT_LO    = 32'h4000,
   parameter int unsigned CONT_HI    = 32'h7FFF,
   parameter bit          IO_CONTEND = 1'b1
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              mem_req_i,
   input  logic              io_req_i,
   input  logic              rd_i,
   input  logic              wr_i,
   output logic              cont_req_o,
   output logic              cont_active_o
);

   localparam longint unsigned SPAN = longint'(CONT_HI) - longint'(CONT_LO) + 1;
   localparam bit ALIGNED = vcc_pkg::is_pow2(SPAN) && ((longint'(CONT_LO) % SPAN) == 0);
   localparam logic [ADDR_W-1:0] LO_V   = ADDR_W'(CONT_LO);
   localparam logic [ADDR_W-1:0] HI_V   = ADDR_W'(CONT_HI);
   localparam logic [ADDR_W-1:0] MASK_V = ~ADDR_W'(SPAN - 1);

   logic in_win;
   logic io_even;

   // Window decode: a power-of-two aligned window needs only a mask compare.
   generate
      if (ALIGNED) begin : g_mask_dec
         assign in_win = ((addr_i & MASK_V) == LO_V);
      end else begin : g_range_dec
         assign in_win = (addr_i >= LO_V) && (addr_i <= HI_V);
      end
   endgenerate

   generate
      if (IO_CONTEND) begin : g_io_on
         assign io_even = io_req_i & ~addr_i[0];
      end else begin : g_io_off
         assign io_even = 1'b0;
      end
   endgenerate

   assign cont_req_o    = (mem_req_i & in_win) | io_even;
   assign cont_active_o = cont_req_o & (rd_i | wr_i);

endmodule

// File: rtl/vcc_fetch_arb.sv
module vcc_fetch_arb #(
   parameter int unsigned FETCH_LEN = 4
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic disp_active_i,
   input  logic fetch_slot_i,
   input  logic cont_active_i,
   output logic grant_o,
   output logic snow_o
);

   localparam int unsigned CW = vcc_pkg::cnt_width(FETCH_LEN);
   localparam logic [CW-1:0] LOAD_V = CW'(FETCH_LEN - 1);

   vcc_pkg::fa_state_e state_q;
   logic [CW-1:0]      cnt_q;
   logic               snow_q;
   logic               busy;
   logic               start;

   // A CPU frozen by an active grant makes no progress and cannot block a fetch.
   assign busy  = cont_active_i & (state_q != vcc_pkg::FA_GRANT);
   assign start = fetch_slot_i & ~busy;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         state_q <= vcc_pkg::FA_IDLE;
         cnt_q   <= '0;
         snow_q  <= 1'b0;
      end else if (!disp_active_i) begin
         state_q <= vcc_pkg::FA_IDLE;
         cnt_q   <= '0;
         snow_q  <= 1'b0;
      end else begin
         if (fetch_slot_i) begin
            snow_q <= busy;
         end
         if (start) begin
            state_q <= vcc_pkg::FA_GRANT;
            cnt_q   <= LOAD_V;
         end else if (state_q == vcc_pkg::FA_GRANT) begin
            if (cnt_q == '0) begin
               state_q <= vcc_pkg::FA_IDLE;
            end else begin
               cnt_q <= cnt_q - CW'(1);
            end
         end
      end
   end

   assign grant_o = (state_q == vcc_pkg::FA_GRANT);
   assign snow_o  = snow_q;

endmodule

// File: rtl/vcc_clk_gate.sv
module vcc_clk_gate (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic hold_i,
   output logic cpu_clk_o
);

   logic cpu_clk_q;

   // Half-rate CPU clock; a hold freezes it only once it is high.
   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         cpu_clk_q <= 1'b1;
      end else if (!(hold_i && cpu_clk_q)) begin
         cpu_clk_q <= ~cpu_clk_q;
      end
   end

   assign cpu_clk_o = cpu_clk_q;

endmodule

// File: rtl/vcc_irq_gen.sv
module vcc_irq_gen #(
   parameter int unsigned IRQ_LEN = 32
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic vsync_i,
   output logic irq_o
);

   localparam int unsigned IW = $clog2(IRQ_LEN + 1);
   localparam logic [IW-1:0] LOAD_V = IW'(IRQ_LEN);

   logic          vs_q;
   logic [IW-1:0] cnt_q;
   logic          rise;

   assign rise = vsync_i & ~vs_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         vs_q  <= 1'b0;
         cnt_q <= '0;
      end else begin
         vs_q <= vsync_i;
         if (rise) begin
            cnt_q <= LOAD_V;
         end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - IW'(1);
         end
      end
   end

   assign irq_o = (cnt_q != '0);

endmodule

// File: rtl/vram_contend_ctrl.sv
module vram_contend_ctrl #(
   parameter int unsigned ADDR_W     = 16,
   parameter int unsigned CONT_LO    = 32'h4000,
   parameter int unsigned CONT_HI    = 32'h7FFF,
   parameter bit          IO_CONTEND = 1'b1,
   parameter int unsigned FETCH_LEN  = 4,
   parameter int unsigned IRQ_LEN    = 32
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [ADDR_W-1:0] cpu_addr_i,
   input  logic              cpu_mem_req_i,
   input  logic              cpu_io_req_i,
   input  logic              cpu_rd_i,
   input  logic              cpu_wr_i,
   input  logic              disp_active_i,
   input  logic              fetch_slot_i,
   input  logic              vsync_i,
   output logic              cpu_clk_o,
   output logic              vid_grant_o,
   output logic              snow_o,
   output logic              irq_o
);

   generate
      if (ADDR_W < 2 || ADDR_W > 32) begin : g_bad_addr_w
         $error("vram_contend_ctrl: ADDR_W must lie in 2..32");
      end
      if (CONT_LO > CONT_HI) begin : g_bad_window
         $error("vram_contend_ctrl: CONT_LO must not exceed CONT_HI");
      end
      if (FETCH_LEN < 1) begin : g_bad_fetch
         $error("vram_contend_ctrl: FETCH_LEN must be at least 1");
      end
      if (IRQ_LEN < 1) begin : g_bad_irq
         $error("vram_contend_ctrl: IRQ_LEN must be at least 1");
      end
   endgenerate

   logic cont_req;
   logic cont_active;
   logic hold;

   vcc_decode #(
      .ADDR_W     (ADDR_W),
      .CONT_LO    (CONT_LO),
      .CONT_HI    (CONT_HI),
      .IO_CONTEND (IO_CONTEND)
   ) u_decode (
      .addr_i        (cpu_addr_i),
      .mem_req_i     (cpu_mem_req_i),
      .io_req_i      (cpu_io_req_i),
      .rd_i          (cpu_rd_i),
      .wr_i          (cpu_wr_i),
      .cont_req_o    (cont_req),
      .cont_active_o (cont_active)
   );

   vcc_fetch_arb #(
      .FETCH_LEN (FETCH_LEN)
   ) u_fetch_arb (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .disp_active_i (disp_active_i),
      .fetch_slot_i  (fetch_slot_i),
      .cont_active_i (cont_active),
      .grant_o       (vid_grant_o),
      .snow_o        (snow_o)
   );

   // Stall only a contended CPU cycle, and only inside the picture area.
   assign hold = vid_grant_o & cont_req & disp_active_i;

   vcc_clk_gate u_clk_gate (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .hold_i    (hold),
      .cpu_clk_o (cpu_clk_o)
   );

   vcc_irq_gen #(
      .IRQ_LEN (IRQ_LEN)
   ) u_irq_gen (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .vsync_i (vsync_i),
      .irq_o   (irq_o)
   );

endmodule

// File: rtl/vcc_checker.sv
module vcc_checker #(
   parameter int unsigned ADDR_W     = 16,
   parameter int unsigned CONT_LO    = 32'h4000,
   parameter int unsigned CONT_HI    = 32'h7FFF,
   parameter bit          IO_CONTEND = 1'b1,
   parameter int unsigned FETCH_LEN  = 4,
   parameter int unsigned IRQ_LEN    = 32
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic [ADDR_W-1:0] cpu_addr_i,
   input logic              cpu_mem_req_i,
   input logic              cpu_io_req_i,
   input logic              cpu_rd_i,
   input logic              cpu_wr_i,
   input logic              disp_active_i,
   input logic              fetch_slot_i,
   input logic              vsync_i,
   input logic              cpu_clk_o,
   input logic              vid_grant_o,
   input logic              snow_o,
   input logic              irq_o
);

   localparam logic [ADDR_W-1:0] LO_V = ADDR_W'(CONT_LO);
   localparam logic [ADDR_W-1:0] HI_V = ADDR_W'(CONT_HI);
   localparam int unsigned RW = $clog2(IRQ_LEN + 2);

   logic          cont;
   logic          busy;
   logic          vs_q;
   logic [RW-1:0] irq_run;

   assign cont = (cpu_mem_req_i && cpu_addr_i >= LO_V && cpu_addr_i <= HI_V) ||
                 (IO_CONTEND && cpu_io_req_i && !cpu_addr_i[0]);
   assign busy = cont && (cpu_rd_i || cpu_wr_i) && !vid_grant_o;

   // Length of the current run of irq_o high.
   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         vs_q    <= 1'b0;
         irq_run <= '0;
      end else begin
         vs_q    <= vsync_i;
         irq_run <= irq_o ? ((vsync_i && !vs_q) ? RW'(1) : irq_run + RW'(1)) : '0;
      end
   end

   a_r1_no_hold_uncont: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cpu_clk_o && !cont) |=> !cpu_clk_o);

   a_r3_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !disp_active_i |=> (!vid_grant_o && !snow_o));

   a_r3_idle_no_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cpu_clk_o && !disp_active_i) |=> !cpu_clk_o);

   a_r4_never_low_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cpu_clk_o |=> cpu_clk_o);

   a_r5_grant_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fetch_slot_i && disp_active_i && !busy) |=> vid_grant_o);

   a_r6_miss_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fetch_slot_i && disp_active_i && busy) |=> (snow_o && !vid_grant_o));

   a_r7_snow_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fetch_slot_i && disp_active_i && !busy) |=> !snow_o);

   a_r7_snow_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!fetch_slot_i && disp_active_i) |=> $stable(snow_o));

   a_r8_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(vid_grant_o) |=> (cpu_clk_o != $past(cpu_clk_o)));

   a_r9_free_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !vid_grant_o |=> (cpu_clk_o != $past(cpu_clk_o)));

   a_r10_irq_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (vsync_i && !vs_q) |=> irq_o);

   a_r10_irq_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_run <= RW'(IRQ_LEN));

   a_r11_reset_vals: assert property (@(posedge clk_i)
      !rst_ni |=> (cpu_clk_o && !vid_grant_o && !snow_o && !irq_o));

endmodule

bind vram_contend_ctrl vcc_checker #(
   .ADDR_W     (ADDR_W),
   .CONT_LO    (CONT_LO),
   .CONT_HI    (CONT_HI),
   .IO_CONTEND (IO_CONTEND),
   .FETCH_LEN  (FETCH_LEN),
   .IRQ_LEN    (IRQ_LEN)
) u_chk (
   .clk_i         (clk_i),
   .rst_ni        (rst_ni),
   .cpu_addr_i    (cpu_addr_i),
   .cpu_mem_req_i (cpu_mem_req_i),
   .cpu_io_req_i  (cpu_io_req_i),
   .cpu_rd_i      (cpu_rd_i),
   .cpu_wr_i      (cpu_wr_i),
   .disp_active_i (disp_active_i),
   .fetch_slot_i  (fetch_slot_i),
   .vsync_i       (vsync_i),
   .cpu_clk_o     (cpu_clk_o),
   .vid_grant_o   (vid_grant_o),
   .snow_o        (snow_o),
   .irq_o         (irq_o)
);

// File: tb/vram_contend_ctrl_tb.sv
module vram_contend_ctrl_tb;

   localparam int CLK_PERIOD = 10;
   localparam int FETCH_LEN  = 4;
   localparam int IRQ_LEN    = 32;
   localparam int NVEC       = 12;
   localparam int WIN        = 12;

   // {addr[25:10], mem[9], io[8], strobe[7], slot[6], disp[5], exp_hold[4:1], exp_snow[0]}
   localparam logic [25:0] VEC [NVEC] = '{
      {16'h4000, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 4'd3, 1'b0},
      {16'h7FFF, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 4'd3, 1'b0},
      {16'h3FFF, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 4'd0, 1'b0},
      {16'h8000, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 4'd0, 1'b0},
      {16'h00FE, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'd3, 1'b0},
      {16'h00FF, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'd0, 1'b0},
      {16'h5000, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 4'd0, 1'b1},
      {16'h00FE, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 4'd0, 1'b1},
      {16'h5000, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 4'd0, 1'b0},
      {16'h5000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 4'd0, 1'b0},
      {16'h8000, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 4'd0, 1'b0},
      {16'h00FF, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 4'd0, 1'b0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] addr = '0;
   logic        mem_req = 1'b0, io_req = 1'b0, rd = 1'b0, wr = 1'b0;
   logic        disp = 1'b0, slot = 1'b0, vsync = 1'b0;
   logic        cpu_clk, grant, snow, irq;
   int          checks = 0;
   int          errors = 0;
   bit          done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   vram_contend_ctrl u_dut (
      .clk_i(clk), .rst_ni(rst_n), .cpu_addr_i(addr),
      .cpu_mem_req_i(mem_req), .cpu_io_req_i(io_req), .cpu_rd_i(rd), .cpu_wr_i(wr),
      .disp_active_i(disp), .fetch_slot_i(slot), .vsync_i(vsync),
      .cpu_clk_o(cpu_clk), .vid_grant_o(grant), .snow_o(snow), .irq_o(irq)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic bit contended(input logic [15:0] a, input logic m, input logic i);
      return (m && a >= 16'h4000 && a <= 16'h7FFF) || (i && !a[0]);
   endfunction

   function automatic string tag_of(input int k);
      case (k)
         0, 1, 2, 3: return "R1";
         4, 5, 11:   return "R2";
         6, 7:       return "R6";
         8:          return "R3";
         9:          return "R9";
         default:    return "R5";
      endcase
   endfunction

   task automatic go_idle();
      @(negedge clk);
      addr = '0; mem_req = 0; io_req = 0; rd = 0; wr = 0; slot = 0; disp = 0;
      @(negedge clk);
      @(negedge clk);
   endtask

   // Wait at a negedge until the CPU clock is high.
   task automatic align_high();
      @(negedge clk);
      while (cpu_clk != 1'b1) @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      // Reset state, R11
      repeat (3) @(negedge clk);
      check("R11", "reset cpu_clk", cpu_clk, 1);
      check("R11", "reset grant", grant, 0);
      check("R11", "reset snow", snow, 0);
      check("R11", "reset irq", irq, 0);
      @(negedge clk);
      rst_n = 1'b1;
      go_idle();

      // Vector table: slot and request applied on the same edge.
      for (int k = 0; k < NVEC; k++) begin
         logic [25:0] v;
         int holds, grants, snow_s, expg;
         logic prev;
         v = VEC[k];
         go_idle();
         disp = v[5];
         align_high();
         addr = v[25:10]; mem_req = v[9]; io_req = v[8]; rd = v[7]; slot = v[6];
         prev = cpu_clk;
         holds = 0; grants = 0; snow_s = 0;
         for (int c = 0; c < WIN; c++) begin
            @(negedge clk);
            if (c == 0) begin
               slot = 1'b0;
               snow_s = snow;
            end
            if (cpu_clk == prev) holds++;
            prev = cpu_clk;
            if (grant) grants++;
         end
         expg = (v[6] && v[5] && !(contended(v[25:10], v[9], v[8]) && v[7])) ? FETCH_LEN : 0;
         check(tag_of(k), $sformatf("vec %0d held cycles", k), holds, int'(v[4:1]));
         check(tag_of(k), $sformatf("vec %0d snow", k), snow_s, int'(v[0]));
         check("R5", $sformatf("vec %0d grant cycles", k), grants, expg);
      end

      // R4 / R8: release timing after a grant with a held CPU.
      begin
         logic prev, seen_grant, released;
         int lowheld;
         go_idle();
         disp = 1'b1;
         align_high();
         addr = 16'h6000; mem_req = 1'b1; slot = 1'b1;
         prev = cpu_clk; seen_grant = 0; released = 0; lowheld = 0;
         for (int c = 0; c < WIN; c++) begin
            @(negedge clk);
            slot = 1'b0;
            if (cpu_clk == prev && cpu_clk == 1'b0) lowheld++;
            prev = cpu_clk;
            if (grant) seen_grant = 1;
            else if (seen_grant && !released) begin
               released = 1;
               check("R8", "clock still high when grant drops", cpu_clk, 1);
               @(negedge clk);
               check("R8", "clock released one edge after grant drops", cpu_clk, 0);
               prev = cpu_clk;
            end
         end
         check("R8", "release observed", released, 1);
         check("R4", "cycles held low", lowheld, 0);
      end

      // R7: snow persists between slots, cleared by a clean slot.
      go_idle();
      disp = 1'b1;
      align_high();
      addr = 16'h4800; mem_req = 1'b1; wr = 1'b1; slot = 1'b1;
      @(negedge clk);
      slot = 1'b0;
      check("R6", "write in progress sets snow", snow, 1);
      check("R6", "no grant on miss", grant, 0);
      repeat (3) @(negedge clk);
      check("R7", "snow held between slots", snow, 1);
      wr = 1'b0; slot = 1'b1;
      @(negedge clk);
      slot = 1'b0;
      check("R7", "snow cleared by clean slot", snow, 0);
      check("R5", "clean slot grants", grant, 1);
      disp = 1'b0;
      @(negedge clk);
      check("R3", "grant dropped when display inactive", grant, 0);

      // R10: interrupt length.
      go_idle();
      begin
         int cnt;
         vsync = 1'b1;
         @(negedge clk);
         check("R10", "irq rises after vsync", irq, 1);
         cnt = irq ? 1 : 0;
         @(negedge clk);
         vsync = 1'b0;
         for (int c = 0; c < IRQ_LEN + 8; c++) begin
            if (irq) cnt++;
            @(negedge clk);
         end
         check("R10", "irq high cycles", cnt, IRQ_LEN);
         check("R10", "irq dropped unacknowledged", irq, 0);
      end

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule